// File: doc/BRIEF.md
# Biquad Coefficient Loader with Gap-Timed Commit

This block sits between a byte-level serial receiver and a second-order recursive filter. It parses a stream of received bytes into a coefficient packet, writes the coefficient bytes into a staging store as they arrive, and checks the packet as a whole with a trailing XOR checksum. The filter never sees a partly written set. A complete, valid packet raises an internal commit-pending flag. The whole staged set is then copied into the live coefficient registers in one clock, and only inside the quiet interval that follows the filter's accumulate phase and precedes its next input sample.

A packet has twelve bytes. The first is the header 0xA5. Ten coefficient bytes follow, carrying b0, b1, b2, a1 and a2 in that order, each as a 16-bit two's complement value with 14 fractional bits, high byte first. The last byte is the XOR of the ten coefficient bytes. A bad header, a bad checksum, or a packet that begins while an earlier one still waits for its commit raises a sticky error flag. The next packet that completes correctly clears it.

The parser is a four-state machine:
- `ST_HUNT` waits for a header.
- `ST_DATA` takes the ten coefficient bytes.
- `ST_CHECK` compares the checksum byte.
- `ST_SKIP` consumes the eleven remaining bytes of a packet that was refused.

Its transitions are:
- HUNT→DATA on a header while nothing is pending.
- HUNT→SKIP on a header while a commit is pending.
- HUNT→HUNT on any other byte.
- DATA→CHECK on the tenth coefficient byte.
- CHECK→HUNT on the checksum byte, whether it matches or not.
- SKIP→HUNT on the eleventh skipped byte.

Top module: `coef_loader`

## Requirements
- R1: After reset the live set is b0 = 0x4000 (unity) with b1, b2, a1 and a2 all 0x0000, and the error flag is low.
- R2: A packet is 0xA5, then ten bytes giving b0, b1, b2, a1, a2 in that order with the high byte of each first, then one byte equal to the XOR of those ten bytes. A packet in this form becomes the live set at its commit.
- R3: A byte is taken only in a cycle with rx_valid high. Values on rx_byte while rx_valid is low, including 0xA5, neither start nor disturb a packet.
- R4: A completed valid packet leaves the live set unchanged until the first cycle in which filt_done is high and sample_stb is low. All five live coefficients change together at that clock edge, and a sample_stb pulse alone commits nothing.
- R5: A filt_done pulse in the same cycle as sample_stb does not commit. The set stays pending for the next filt_done.
- R6: A byte other than 0xA5 taken while hunting for a header sets the error flag and leaves the live set unchanged. The parser keeps hunting, so a following correct packet is accepted.
- R7: A packet whose checksum byte does not match sets the error flag, and its staged data is never committed, even after later filt_done pulses.
- R8: The error flag stays set until the checksum byte of a correct packet is taken. It clears on that clock edge.
- R9: A header that arrives while a commit is pending sets the error flag, and the header plus the eleven bytes after it are dropped. The pending set is still committed on the next filt_done, unchanged by the dropped bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | rx_byte holds a new byte this cycle |
| filt_done | input | 1 | One-cycle pulse: the filter has finished accumulating |
| sample_stb | input | 1 | One-cycle pulse: the filter takes its next input sample |
| coef_b0 | output | 16 | Live feed-forward coefficient b0, Q2.14 |
| coef_b1 | output | 16 | Live feed-forward coefficient b1, Q2.14 |
| coef_b2 | output | 16 | Live feed-forward coefficient b2, Q2.14 |
| coef_a1 | output | 16 | Live feedback coefficient a1, Q2.14 |
| coef_a2 | output | 16 | Live feedback coefficient a2, Q2.14 |
| coef_err | output | 1 | Sticky packet error flag |

## Verification
The assertions assume that filt_done and sample_stb are single-cycle pulses from the filter's sequencer. They also assume that a commit can only be asked for after a checksum byte has been accepted, so every change to the live set or to the pending flag must follow an accepted byte or a filt_done. The bench honours this: it raises rx_valid for exactly one cycle per byte, pulses filt_done and sample_stb for one cycle each, and drives every input on the falling edge. When filt_done and sample_stb coincide, it is only in the scenario written to show that clash. Idle cycles carry junk on rx_byte with rx_valid low, including the header value, so that only flagged bytes can advance the parser.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;

    // Number of coefficients in a biquad set: b0, b1, b2, a1, a2.
    localparam int NCOEF = 5;

    typedef enum logic [1:0] {
        ST_HUNT,    // waiting for a header byte
        ST_DATA,    // collecting coefficient bytes
        ST_CHECK,   // waiting for the checksum byte
        ST_SKIP     // discarding the body of a refused packet
    } parse_st_e;

endpackage

// File: rtl/coef_parser.sv
module coef_parser
    import coef_loader_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int COEF_W = 16,
    parameter int N_COEF = NCOEF,
    parameter logic [BYTE_W-1:0] HDR = 8'hA5
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [BYTE_W-1:0]                         rx_byte,
    input  logic                                      rx_valid,
    input  logic                                      pend_i,
    output logic                                      wr_en_o,
    output logic [$clog2(N_COEF*(COEF_W/BYTE_W)+1)-1:0] wr_idx_o,
    output logic [BYTE_W-1:0]                         wr_data_o,
    output logic                                      pkt_ok_o,
    output logic                                      err_o
);

    localparam int BPC    = COEF_W / BYTE_W;
    localparam int NBYTES = N_COEF * BPC;
    localparam int CNT_W  = $clog2(NBYTES + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(NBYTES - 1);
    localparam logic [CNT_W-1:0] LAST_SKIP = CNT_W'(NBYTES);

    parse_st_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] csum_q;
    logic              err_q;
    logic              hdr_hit;
    logic              sum_hit;
    logic              err_set;

    assign hdr_hit = (rx_byte == HDR);
    assign sum_hit = (rx_byte == csum_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (rx_valid && hdr_hit) begin
                    state_d = pend_i ? ST_SKIP : ST_DATA;
                end
            end
            ST_DATA: begin
                if (rx_valid && (cnt_q == LAST_DATA)) begin
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (rx_valid) begin
                    state_d = ST_HUNT;
                end
            end
            ST_SKIP: begin
                if (rx_valid && (cnt_q == LAST_SKIP)) begin
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        wr_en_o  = 1'b0;
        pkt_ok_o = 1'b0;
        err_set  = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                err_set = rx_valid && (!hdr_hit || pend_i);
            end
            ST_DATA: begin
                wr_en_o = rx_valid;
            end
            ST_CHECK: begin
                pkt_ok_o = rx_valid && sum_hit;
                err_set  = rx_valid && !sum_hit;
            end
            ST_SKIP: begin
                wr_en_o = 1'b0;
            end
            default: begin
                wr_en_o = 1'b0;
            end
        endcase
    end

    assign wr_idx_o  = cnt_q;
    assign wr_data_o = rx_byte;
    assign err_o     = err_q;

    // Byte counter, running checksum and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            csum_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (state_q == ST_HUNT) begin
                cnt_q  <= '0;
                csum_q <= '0;
            end else if (rx_valid && (state_q == ST_DATA)) begin
                cnt_q  <= cnt_q + 1'b1;
                csum_q <= csum_q ^ rx_byte;
            end else if (rx_valid && (state_q == ST_SKIP)) begin
                cnt_q <= cnt_q + 1'b1;
            end

            if (err_set) begin
                err_q <= 1'b1;
            end else if (pkt_ok_o) begin
                err_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/coef_stage_mem.sv
module coef_stage_mem
    import coef_loader_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int COEF_W = 16,
    parameter int N_COEF = NCOEF
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      wr_en,
    input  logic [$clog2(N_COEF*(COEF_W/BYTE_W)+1)-1:0] wr_idx,
    input  logic [BYTE_W-1:0]                         wr_data,
    output logic [N_COEF*COEF_W-1:0]                  stage_o
);

    localparam int BPC   = COEF_W / BYTE_W;
    localparam int CNT_W = $clog2(N_COEF * BPC + 1);

    // One byte lane per (coefficient, lane); the first byte of a
    // coefficient on the wire lands in its most significant lane.
    for (genvar e = 0; e < N_COEF; e++) begin : g_entry
        for (genvar l = 0; l < BPC; l++) begin : g_lane
            localparam int SLOT = e * BPC + (BPC - 1 - l);
            logic [BYTE_W-1:0] lane_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else if (wr_en && (wr_idx == CNT_W'(SLOT))) begin
                    lane_q <= wr_data;
                end
            end

            assign stage_o[e*COEF_W + l*BYTE_W +: BYTE_W] = lane_q;
        end
    end

endmodule

// File: rtl/coef_commit.sv
module coef_commit
    import coef_loader_pkg::*;
#(
    parameter int COEF_W    = 16,
    parameter int FRAC_BITS = 14,
    parameter int N_COEF    = NCOEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     filt_done,
    input  logic                     sample_stb,
    input  logic                     pkt_ok,
    input  logic [N_COEF*COEF_W-1:0] stage_i,
    output logic [N_COEF*COEF_W-1:0] active_o,
    output logic                     pend_o
);

    localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_BITS;

    logic pend_q;
    logic commit;

    // Copy only inside the gap: accumulate finished, no sample this cycle.
    assign commit = pend_q && filt_done && !sample_stb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (pkt_ok) begin
            pend_q <= 1'b1;
        end else if (commit) begin
            pend_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < N_COEF; i++) begin : g_live
        localparam logic [COEF_W-1:0] RST_VAL = (i == 0) ? UNITY : '0;
        logic [COEF_W-1:0] live_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                live_q <= RST_VAL;
            end else if (commit) begin
                live_q <= stage_i[i*COEF_W +: COEF_W];
            end
        end

        assign active_o[i*COEF_W +: COEF_W] = live_q;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/coef_loader.sv
module coef_loader
    import coef_loader_pkg::*;
#(
    parameter int COEF_W    = 16,
    parameter int FRAC_BITS = 14,
    parameter logic [7:0] HDR = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_byte,
    input  logic              rx_valid,
    input  logic              filt_done,
    input  logic              sample_stb,
    output logic [COEF_W-1:0] coef_b0,
    output logic [COEF_W-1:0] coef_b1,
    output logic [COEF_W-1:0] coef_b2,
    output logic [COEF_W-1:0] coef_a1,
    output logic [COEF_W-1:0] coef_a2,
    output logic              coef_err
);

    localparam int BYTE_W = 8;
    localparam int BPC    = COEF_W / BYTE_W;
    localparam int CNT_W  = $clog2(NCOEF * BPC + 1);

    logic                    wr_en;
    logic [CNT_W-1:0]        wr_idx;
    logic [BYTE_W-1:0]       wr_data;
    logic                    pkt_ok;
    logic                    commit_pend;
    logic [NCOEF*COEF_W-1:0] stage_flat;
    logic [NCOEF*COEF_W-1:0] active_flat;

    coef_parser #(
        .BYTE_W (BYTE_W),
        .COEF_W (COEF_W),
        .N_COEF (NCOEF),
        .HDR    (HDR)
    ) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .pend_i    (commit_pend),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data),
        .pkt_ok_o  (pkt_ok),
        .err_o     (coef_err)
    );

    coef_stage_mem #(
        .BYTE_W (BYTE_W),
        .COEF_W (COEF_W),
        .N_COEF (NCOEF)
    ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .stage_o (stage_flat)
    );

    coef_commit #(
        .COEF_W    (COEF_W),
        .FRAC_BITS (FRAC_BITS),
        .N_COEF    (NCOEF)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_done  (filt_done),
        .sample_stb (sample_stb),
        .pkt_ok     (pkt_ok),
        .stage_i    (stage_flat),
        .active_o   (active_flat),
        .pend_o     (commit_pend)
    );

    assign coef_b0 = active_flat[0*COEF_W +: COEF_W];
    assign coef_b1 = active_flat[1*COEF_W +: COEF_W];
    assign coef_b2 = active_flat[2*COEF_W +: COEF_W];
    assign coef_a1 = active_flat[3*COEF_W +: COEF_W];
    assign coef_a2 = active_flat[4*COEF_W +: COEF_W];

endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int FLAT_W = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              filt_done,
    input logic              sample_stb,
    input logic              err_flag,
    input logic              pend,
    input logic [FLAT_W-1:0] coefs
);

    // R4: the live set moves only on a gap edge with a set waiting
    p_coef_move_in_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(coefs) |-> ($past(filt_done) && !$past(sample_stb) && $past(pend)));

    // R4: the pending flag drops only through a gap-timed commit
    p_pend_drop_on_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend) |-> ($past(filt_done) && !$past(sample_stb)));

    // R5: a done pulse clashing with a sample pulse leaves the set alone
    p_no_commit_on_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_done && sample_stb) |=> $stable(coefs));

    // R2: a set becomes pending only when a byte was taken
    p_pend_rise_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(rx_valid));

    // R6: the error flag is raised only by a taken byte
    p_err_rise_on_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(rx_valid));

    // R8: the error flag clears only with a good packet becoming pending
    p_err_clear_on_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag) |-> $rose(pend));

endmodule

bind coef_loader coef_loader_chk #(
    .FLAT_W (5 * COEF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .filt_done  (filt_done),
    .sample_stb (sample_stb),
    .err_flag   (coef_err),
    .pend       (commit_pend),
    .coefs      (active_flat)
);

// File: tb/test_coef_loader.sv
`timescale 1ns/1ps
module test_coef_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_valid = 1'b0;
    logic        filt_done = 1'b0;
    logic        sample_stb = 1'b0;
    logic [15:0] coef_b0, coef_b1, coef_b2, coef_a1, coef_a2;
    logic        coef_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    logic [4:0][15:0] exp_c;
    logic             exp_err;

    always #2.5 clk = ~clk;

    coef_loader i_coef_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .filt_done  (filt_done),
        .sample_stb (sample_stb),
        .coef_b0    (coef_b0),
        .coef_b1    (coef_b1),
        .coef_b2    (coef_b2),
        .coef_a1    (coef_a1),
        .coef_a2    (coef_a2),
        .coef_err   (coef_err)
    );

    task automatic cmp(input string req, input string what,
                       input logic [15:0] got, input logic [15:0] want);
        n_chk++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, want);
        end
    endtask

    task automatic check_all(input string req);
        cmp(req, "b0", coef_b0, exp_c[0]);
        cmp(req, "b1", coef_b1, exp_c[1]);
        cmp(req, "b2", coef_b2, exp_c[2]);
        cmp(req, "a1", coef_a1, exp_c[3]);
        cmp(req, "a2", coef_a2, exp_c[4]);
        cmp(req, "err", {15'd0, coef_err}, {15'd0, exp_err});
    endtask

    // One byte with rx_valid for one cycle; optionally one junk cycle after.
    task automatic send_byte(input logic [7:0] b, input bit junk);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_byte  = 8'h5A;
        if (junk) begin
            rx_byte = 8'hA5;
            @(negedge clk);
            rx_byte = 8'h3C;
        end
    endtask

    task automatic send_pkt(input logic [4:0][15:0] c, input bit bad_sum, input bit junk);
        logic [7:0] x = 8'h00;
        send_byte(8'hA5, junk);
        for (int i = 0; i < 5; i++) begin
            send_byte(c[i][15:8], junk);
            send_byte(c[i][7:0], junk);
            x = x ^ c[i][15:8] ^ c[i][7:0];
        end
        send_byte(bad_sum ? (x ^ 8'h01) : x, junk);
    endtask

    task automatic pulse(input bit done, input bit smp);
        @(negedge clk);
        filt_done  = done;
        sample_stb = smp;
        @(negedge clk);
        filt_done  = 1'b0;
        sample_stb = 1'b0;
    endtask

    task automatic t_reset();
        exp_c   = '0;
        exp_c[0] = 16'h4000;
        exp_err = 1'b0;
        check_all("R1");
    endtask

    task automatic t_basic();
        logic [4:0][15:0] p;
        p = {16'hF123, 16'h2D44, 16'hC001, 16'h8000, 16'h3FFF};
        send_pkt(p, 1'b0, 1'b0);
        check_all("R4 held while pending");
        pulse(1'b0, 1'b1);
        check_all("R4 sample alone");
        pulse(1'b1, 1'b0);
        exp_c = p;
        check_all("R2 committed");
    endtask

    task automatic t_clash();
        logic [4:0][15:0] p;
        p = {16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h090A};
        send_pkt(p, 1'b0, 1'b0);
        pulse(1'b1, 1'b1);
        check_all("R5 clash no commit");
        pulse(1'b1, 1'b0);
        exp_c = p;
        check_all("R5 next done commits");
    endtask

    task automatic t_gaps();
        logic [4:0][15:0] p;
        p = {16'hA5A5, 16'h00A5, 16'hFFFF, 16'h1234, 16'hBEEF};
        repeat (3) begin
            @(negedge clk);
            rx_byte = 8'hA5;
        end
        check_all("R3 unflagged header ignored");
        send_pkt(p, 1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        exp_c = p;
        check_all("R3 packet with idle junk");
    endtask

    task automatic t_bad_hdr();
        logic [4:0][15:0] p;
        p = {16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555};
        send_byte(8'h3C, 1'b0);
        exp_err = 1'b1;
        check_all("R6 wrong header");
        pulse(1'b1, 1'b0);
        check_all("R6 live set unchanged");
        send_pkt(p, 1'b0, 1'b0);
        exp_err = 1'b0;
        check_all("R8 error cleared on good packet");
        pulse(1'b1, 1'b0);
        exp_c = p;
        check_all("R6 hunt resumes");
    endtask

    task automatic t_bad_sum();
        logic [4:0][15:0] p;
        p = {16'h6666, 16'h7777, 16'h8888, 16'h9999, 16'hAAAA};
        send_pkt(p, 1'b1, 1'b0);
        exp_err = 1'b1;
        check_all("R7 checksum mismatch");
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        check_all("R7 staged data not committed");
        send_byte(8'h77, 1'b0);
        check_all("R8 error sticky");
    endtask

    task automatic t_busy();
        logic [4:0][15:0] pa, pb, pc;
        pa = {16'h0A0B, 16'h0C0D, 16'h0E0F, 16'h1011, 16'h1213};
        pb = {16'hDEAD, 16'hA5A5, 16'hCAFE, 16'hF00D, 16'h0BAD};
        pc = {16'h7FFF, 16'h8001, 16'h0000, 16'hFFFE, 16'h4000};
        send_pkt(pa, 1'b0, 1'b0);
        exp_err = 1'b0;
        check_all("R9 first packet pending");
        send_pkt(pb, 1'b0, 1'b0);
        exp_err = 1'b1;
        check_all("R9 header while pending");
        pulse(1'b1, 1'b0);
        exp_c = pa;
        check_all("R9 pending set committed");
        send_pkt(pc, 1'b0, 1'b0);
        exp_err = 1'b0;
        pulse(1'b1, 1'b0);
        exp_c = pc;
        check_all("R9 parser realigned");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clash();
        t_gaps();
        t_bad_hdr();
        t_bad_sum();
        t_busy();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule